// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the memory address for a load or store. It adds an offset to a base register value or subtracts the offset from it, and it raises a read or write strobe to match the access type. The offset takes one of two forms. It can be a 12-bit immediate, which is zero-extended. It can also be a register value passed through a barrel shifter, which offers a left logical shift, a right logical shift, a right arithmetic shift or a right rotate, with a 5-bit amount.

Each instruction bit arrives as its own input: a format select, an up/down bit and a load/store bit. One registered stage sits between the inputs and the outputs. The address register is written only when an instruction is marked valid, so the last address stays on the output while the input is idle.

Top module: `lsag_top`

## Requirements
- R1: While rst_ni is low, addr_o, rd_en_o and wr_en_o are all 0.
- R2: With reg_form_i=0 and up_i=1, addr_o one cycle after a valid input equals base_i plus imm_i zero-extended to 32 bits.
- R3: With up_i=0 the offset is subtracted from base_i instead of added.
- R4: An offset of zero, whether an immediate of 0 or a register offset of 0, yields addr_o equal to base_i.
- R5: With reg_form_i=1 and sh_kind_i=2'b00, the register offset is shifted left by sh_amt_i with zero fill before it is applied, so an index shifted by 2 scales by 4.
- R6: sh_kind_i=2'b01 shifts the register offset right with zero fill.
- R7: sh_kind_i=2'b10 shifts the register offset right and fills with copies of bit 31.
- R8: sh_kind_i=2'b11 rotates the register offset right, so bits shifted out at bit 0 re-enter at bit 31.
- R9: sh_amt_i=0 leaves the register offset unchanged for every shift kind.
- R10: Address arithmetic wraps modulo 2^32 in both the add and the subtract direction.
- R11: A valid input with load_i=1 gives rd_en_o=1 and wr_en_o=0 on the next cycle.
- R12: A valid input with load_i=0 gives wr_en_o=1 and rd_en_o=0 on the next cycle.
- R13: When valid_i is 0, both strobes are 0 on the next cycle and addr_o keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction present this cycle |
| load_i | input | 1 | 1 = load, 0 = store |
| up_i | input | 1 | 1 = add offset, 0 = subtract offset |
| reg_form_i | input | 1 | 1 = shifted register offset, 0 = immediate offset |
| base_i | input | 32 | Base register value |
| imm_i | input | 12 | Immediate offset, unsigned |
| roff_i | input | 32 | Register offset value |
| sh_kind_i | input | 2 | 00 left, 01 right logical, 10 right arithmetic, 11 rotate right |
| sh_amt_i | input | 5 | Shift amount, 0 to 31 |
| addr_o | output | 32 | Effective address |
| rd_en_o | output | 1 | Read strobe |
| wr_en_o | output | 1 | Write strobe |

## Verification
Every result is due exactly one clock edge after its inputs are applied. The address, the read strobe and the write strobe all come from the same output register stage. The bench changes inputs on the falling edge, lets one rising edge capture them, and reads the outputs at the next falling edge. It then drops valid_i, so the hold-on-idle behaviour can be observed on the following cycle. Expected addresses come from a separate model that uses the language's own shift and add operators.

// File: rtl/lsag_pkg.sv
package lsag_pkg;
  // encoding is decoded from the instruction field; order is fixed
  typedef enum logic [1:0] {
    SH_LEFT      = 2'b00,
    SH_RIGHT_LOG = 2'b01,
    SH_RIGHT_ARI = 2'b10,
    SH_ROTATE    = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/lsag_shifter.sv
module lsag_shifter
  import lsag_pkg::*;
#(
  parameter int W    = 32,
  parameter int SH_W = $clog2(W)
) (
  input  logic [W-1:0]    data_i,
  input  shift_kind_e     kind_i,
  input  logic [SH_W-1:0] amt_i,
  output logic [W-1:0]    data_o
);
  logic [W-1:0] stage [0:SH_W];
  assign stage[0] = data_i;

  // log-depth barrel: stage k moves by 2^k when amt bit k is set
  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [W-1:0] cur, moved;
    assign cur = stage[k];
    always_comb begin
      unique case (kind_i)
        SH_LEFT:      moved = {cur[W-1-S:0], {S{1'b0}}};
        SH_RIGHT_LOG: moved = {{S{1'b0}}, cur[W-1:S]};
        SH_RIGHT_ARI: moved = {{S{cur[W-1]}}, cur[W-1:S]};
        SH_ROTATE:    moved = {cur[S-1:0], cur[W-1:S]};
        default:      moved = cur;
      endcase
    end
    assign stage[k+1] = amt_i[k] ? moved : cur;
  end

  assign data_o = stage[SH_W];
endmodule

// File: rtl/lsag_offset_mux.sv
module lsag_offset_mux #(
  parameter int W     = 32,
  parameter int IMM_W = 12
) (
  input  logic             reg_form_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [W-1:0]     shifted_i,
  output logic [W-1:0]     offset_o
);
  logic [W-1:0] imm_ext;
  assign imm_ext  = {{(W-IMM_W){1'b0}}, imm_i};
  assign offset_o = reg_form_i ? shifted_i : imm_ext;
endmodule

// File: rtl/lsag_addr_calc.sv
module lsag_addr_calc #(
  parameter int W = 32
) (
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] offset_i,
  input  logic         up_i,
  output logic [W-1:0] addr_o
);
  // single adder; subtract via inverted offset and carry-in
  logic [W-1:0] opnd;
  assign opnd   = up_i ? offset_i : ~offset_i;
  assign addr_o = base_i + opnd + {{(W-1){1'b0}}, ~up_i};
endmodule

// File: rtl/lsag_top.sv
module lsag_top
  import lsag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 12,
  localparam int SH_W  = $clog2(ADDR_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              load_i,
  input  logic              up_i,
  input  logic              reg_form_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [ADDR_W-1:0] roff_i,
  input  logic [1:0]        sh_kind_i,
  input  logic [SH_W-1:0]   sh_amt_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_en_o,
  output logic              wr_en_o
);
  logic [ADDR_W-1:0] shifted, offset, addr_d;

  lsag_shifter #(.W(ADDR_W), .SH_W(SH_W)) u_shift (
    .data_i (roff_i),
    .kind_i (shift_kind_e'(sh_kind_i)),
    .amt_i  (sh_amt_i),
    .data_o (shifted)
  );

  lsag_offset_mux #(.W(ADDR_W), .IMM_W(IMM_W)) u_omux (
    .reg_form_i (reg_form_i),
    .imm_i      (imm_i),
    .shifted_i  (shifted),
    .offset_o   (offset)
  );

  lsag_addr_calc #(.W(ADDR_W)) u_calc (
    .base_i   (base_i),
    .offset_i (offset),
    .up_i     (up_i),
    .addr_o   (addr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      rd_en_o <= 1'b0;
      wr_en_o <= 1'b0;
    end else begin
      rd_en_o <= valid_i & load_i;
      wr_en_o <= valid_i & ~load_i;
      if (valid_i) addr_o <= addr_d;
    end
  end
endmodule

// File: rtl/lsag_chk.sv
module lsag_chk #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              load_i,
  input logic              up_i,
  input logic              reg_form_i,
  input logic [ADDR_W-1:0] base_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              rd_en_o,
  input logic              wr_en_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_quiet: assert (addr_o == '0 && !rd_en_o && !wr_en_o);
    end
  end

  a_r2_imm_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && !reg_form_i && up_i) |->
      addr_o == $past(base_i) + {{(ADDR_W-IMM_W){1'b0}}, $past(imm_i)});

  a_r3_imm_sub: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && !reg_form_i && !up_i) |->
      addr_o == $past(base_i) - {{(ADDR_W-IMM_W){1'b0}}, $past(imm_i)});

  a_r11_read_from_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> $past(valid_i && load_i));

  a_r12_write_from_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(valid_i && !load_i));

  a_r12_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_en_o, wr_en_o}));

  a_r13_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> ($stable(addr_o) && !rd_en_o && !wr_en_o));
endmodule

bind lsag_top lsag_chk #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .load_i     (load_i),
  .up_i       (up_i),
  .reg_form_i (reg_form_i),
  .base_i     (base_i),
  .imm_i      (imm_i),
  .addr_o     (addr_o),
  .rd_en_o    (rd_en_o),
  .wr_en_o    (wr_en_o)
);

// File: tb/lsag_top_bench.sv
module lsag_top_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, load_i = 1'b0, up_i = 1'b0, reg_form_i = 1'b0;
  logic [31:0] base_i = '0, roff_i = '0;
  logic [11:0] imm_i = '0;
  logic [1:0]  sh_kind_i = '0;
  logic [4:0]  sh_amt_i = '0;
  logic [31:0] addr_o;
  logic        rd_en_o, wr_en_o;

  int total = 0;
  int bad   = 0;

  always #2 clk_i = ~clk_i;

  lsag_top u_lsag_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .load_i(load_i),
    .up_i(up_i), .reg_form_i(reg_form_i), .base_i(base_i), .imm_i(imm_i),
    .roff_i(roff_i), .sh_kind_i(sh_kind_i), .sh_amt_i(sh_amt_i),
    .addr_o(addr_o), .rd_en_o(rd_en_o), .wr_en_o(wr_en_o)
  );

  function automatic logic [31:0] model_shift(logic [31:0] x, logic [1:0] k, logic [4:0] a);
    case (k)
      2'b00:   return x << a;
      2'b01:   return x >> a;
      2'b10:   return 32'($signed(x) >>> a);
      default: return (a == 0) ? x : ((x >> a) | (x << (6'd32 - {1'b0, a})));
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one instruction, sample outputs one cycle later, then go idle
  task automatic run_op(logic ld, logic up, logic rf, logic [31:0] base,
                        logic [11:0] imm, logic [31:0] roff, logic [1:0] k,
                        logic [4:0] a);
    @(negedge clk_i);
    valid_i = 1'b1; load_i = ld; up_i = up; reg_form_i = rf;
    base_i = base; imm_i = imm; roff_i = roff; sh_kind_i = k; sh_amt_i = a;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 addr", addr_o, 32'h0);
    check("R1 strobes", {30'h0, rd_en_o, wr_en_o}, 32'h0);
  endtask

  task automatic t_imm_up;
    run_op(1, 1, 0, 32'h0000_1000, 12'hFFF, 32'hDEAD_BEEF, 2'b00, 5'd3);
    check("R2 imm add", addr_o, 32'h0000_1FFF);
  endtask

  task automatic t_imm_down;
    run_op(1, 0, 0, 32'h0000_1000, 12'h004, '0, 2'b00, 5'd0);
    check("R3 imm sub", addr_o, 32'h0000_0FFC);
    run_op(0, 0, 1, 32'h0000_0100, 12'h0, 32'h10, 2'b00, 5'd2);
    check("R3 reg sub", addr_o, 32'h0000_00C0);
  endtask

  task automatic t_zero_off;
    run_op(1, 1, 0, 32'h1234_5678, 12'h0, 32'hFFFF_FFFF, 2'b00, 5'd0);
    check("R4 zero imm", addr_o, 32'h1234_5678);
    run_op(1, 0, 1, 32'h8765_4321, 12'hABC, 32'h0, 2'b10, 5'd7);
    check("R4 zero reg", addr_o, 32'h8765_4321);
  endtask

  task automatic t_shift_kinds;
    logic [31:0] r = 32'hC000_0007;
    run_op(1, 1, 1, 32'h0000_2000, 12'h0, 32'd5, 2'b00, 5'd2);
    check("R5 lsl x4", addr_o, 32'h0000_2014);
    run_op(1, 1, 1, 32'h0, 12'h0, r, 2'b00, 5'd31);
    check("R5 lsl 31", addr_o, model_shift(r, 2'b00, 5'd31));
    run_op(1, 1, 1, 32'h10, 12'h0, 32'h8000_0400, 2'b01, 5'd2);
    check("R6 lsr", addr_o, 32'h2000_0110);
    run_op(1, 1, 1, 32'h0, 12'h0, 32'hFFFF_FC00, 2'b10, 5'd2);
    check("R7 asr neg", addr_o, 32'hFFFF_FF00);
    run_op(1, 1, 1, 32'h0, 12'h0, 32'h7000_0000, 2'b10, 5'd4);
    check("R7 asr pos", addr_o, 32'h0700_0000);
    run_op(1, 1, 1, 32'h0, 12'h0, 32'h0000_0007, 2'b11, 5'd2);
    check("R8 ror", addr_o, 32'hC000_0001);
    run_op(1, 1, 1, 32'h0, 12'h0, r, 2'b11, 5'd17);
    check("R8 ror 17", addr_o, model_shift(r, 2'b11, 5'd17));
  endtask

  task automatic t_amt_zero;
    for (int k = 0; k < 4; k++) begin
      run_op(1, 1, 1, 32'h0, 12'h0, 32'h8000_0001, 2'(k), 5'd0);
      check("R9 amount zero", addr_o, 32'h8000_0001);
    end
  endtask

  task automatic t_wrap;
    run_op(1, 1, 0, 32'hFFFF_FFF0, 12'h020, '0, 2'b00, 5'd0);
    check("R10 add wrap", addr_o, 32'h0000_0010);
    run_op(1, 0, 1, 32'h0000_0004, 12'h0, 32'h8, 2'b00, 5'd0);
    check("R10 sub wrap", addr_o, 32'hFFFF_FFFC);
  endtask

  task automatic t_strobes;
    run_op(1, 1, 0, 32'h40, 12'h4, '0, 2'b00, 5'd0);
    check("R11 load rd", {31'h0, rd_en_o}, 32'h1);
    check("R11 load wr", {31'h0, wr_en_o}, 32'h0);
    run_op(0, 1, 0, 32'h40, 12'h8, '0, 2'b00, 5'd0);
    check("R12 store wr", {31'h0, wr_en_o}, 32'h1);
    check("R12 store rd", {31'h0, rd_en_o}, 32'h0);
  endtask

  task automatic t_idle;
    run_op(1, 1, 0, 32'h0000_5000, 12'h010, '0, 2'b00, 5'd0);
    check("R13 setup", addr_o, 32'h0000_5010);
    // valid low now; change every other input
    base_i = 32'hFFFF_0000; imm_i = 12'h777; load_i = 1'b0; up_i = 1'b0;
    @(negedge clk_i);
    check("R13 addr held", addr_o, 32'h0000_5010);
    check("R13 strobes low", {30'h0, rd_en_o, wr_en_o}, 32'h0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_imm_up();
        t_imm_down();
        t_zero_off();
        t_shift_kinds();
        t_amt_zero();
        t_wrap();
        t_strobes();
        t_idle();
      end
      begin
        repeat (20000) @(posedge clk_i);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule